// File: doc/BRIEF.md
# Multi-Mode 4-Bit Counter

This block is a small up-counter built from a state register and a next-state
calculation, with a two-bit selector that picks how it behaves at its limits.
In wrap mode it runs from 0 to 15 and then starts again at 0. In saturate mode
it climbs to 15 and stays there until reset. In bounce mode it climbs to 15,
turns, falls to 0, turns again, and repeats this indefinitely.

Bounce mode needs a direction flag inside the block. The flag is not visible at
the ports; its effect shows only in the count sequence. A count-enable input
freezes all state, and a synchronous active-high reset returns the counter to 0
with the direction set to up. The selector may change while counting: the count
carries on from its present value. The block has no data stream, so every pin is
a plain control or status pin with no handshake.

Top module: `mmode_counter`

## Requirements
- R1: On a rising clock edge with `rst` high, `count` becomes 0 and the internal direction becomes up. This takes priority over `en` and `mode`, so it also happens with `en` low.
- R2: On an edge with `rst` low and `en` low, `count` and the direction both keep their values.
- R3: With `mode` = 2'b00 (wrap) and `en` high, each edge adds 1 to `count`, and 15 is followed by 0.
- R4: With `mode` = 2'b01 (saturate) and `en` high, each edge adds 1 to `count` below 15, and a count of 15 stays at 15.
- R5: With `mode` = 2'b10 (bounce) and `en` high, starting from reset the count runs 0,1,...,15,14,...,0,1,... Each edge moves the count by exactly 1. 15 and 0 each last one enabled cycle before the count turns.
- R6: `mode` = 2'b11 behaves exactly like wrap mode.
- R7: A change of `mode` keeps the present count. Any enabled edge outside bounce mode sets the direction to up, so a later return to bounce counts upward first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; low freezes count and direction |
| mode | input | 2 | Behaviour select: 00 wrap, 01 saturate, 10 bounce, 11 wrap |
| count | output | 4 | Current count value |

## Verification
The only internal state that the ports do not show is the bounce direction flag. A wrong flag does not change `count` at once. It shows on the next enabled bounce edge, which moves the count the wrong way: for example 10 then 9 where 11 was due after a return from another mode, or 14 then 13 where 15 was due. A frozen flag or count under a low `en` shows as soon as enable returns. The bench therefore samples `count` on the enabled edge right after each mode change, hold interval and turn point. Errors in the count register itself show one edge after the edge that causes them.

// File: rtl/mmode_counter_pkg.sv
package mmode_counter_pkg;

  typedef enum logic [1:0] {
    BHV_WRAP   = 2'b00,
    BHV_SAT    = 2'b01,
    BHV_BOUNCE = 2'b10
  } behave_t;

  // 2'b11 is folded onto wrap
  function automatic behave_t decode_mode(input logic [1:0] sel);
    case (sel)
      2'b01:   return BHV_SAT;
      2'b10:   return BHV_BOUNCE;
      default: return BHV_WRAP;
    endcase
  endfunction

endpackage

// File: rtl/mmode_cnt_arith.sv
module mmode_cnt_arith #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] inc,
  output logic [WIDTH-1:0] dec,
  output logic             at_top,
  output logic             at_bot
);
  localparam logic [WIDTH-1:0] TOP = '1;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    inc    = cur + ONE;
    dec    = cur - ONE;
    at_top = (cur == TOP);
    at_bot = (cur == '0);
  end
endmodule

// File: rtl/mmode_cnt_policy.sv
module mmode_cnt_policy
  import mmode_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [1:0]       mode,
  input  logic             dir_up,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] inc,
  input  logic [WIDTH-1:0] dec,
  input  logic             at_top,
  input  logic             at_bot,
  output logic [WIDTH-1:0] nxt,
  output logic             nxt_dir_up
);
  behave_t bhv;

  always_comb begin
    bhv        = decode_mode(mode);
    nxt        = inc;
    nxt_dir_up = 1'b1;
    case (bhv)
      BHV_SAT: begin
        nxt = at_top ? cur : inc;
      end
      BHV_BOUNCE: begin
        if (dir_up) begin
          if (at_top) begin
            nxt        = dec;
            nxt_dir_up = 1'b0;
          end else begin
            nxt        = inc;
            nxt_dir_up = 1'b1;
          end
        end else begin
          if (at_bot) begin
            nxt        = inc;
            nxt_dir_up = 1'b1;
          end else begin
            nxt        = dec;
            nxt_dir_up = 1'b0;
          end
        end
      end
      default: begin
        nxt = inc;
      end
    endcase
  end
endmodule

// File: rtl/mmode_cnt_state.sv
module mmode_cnt_state #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] nxt,
  input  logic             nxt_dir_up,
  output logic [WIDTH-1:0] cur,
  output logic             dir_up
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur    <= '0;
      dir_up <= 1'b1;
    end else if (en) begin
      cur    <= nxt;
      dir_up <= nxt_dir_up;
    end
  end
endmodule

// File: rtl/mmode_counter.sv
module mmode_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       mode,
  output logic [WIDTH-1:0] count
);
  logic [WIDTH-1:0] cur, inc, dec, nxt;
  logic             at_top, at_bot, dir_up, nxt_dir_up;

  mmode_cnt_arith #(.WIDTH(WIDTH)) u_arith (
    .cur(cur), .inc(inc), .dec(dec), .at_top(at_top), .at_bot(at_bot)
  );

  mmode_cnt_policy #(.WIDTH(WIDTH)) u_policy (
    .mode(mode), .dir_up(dir_up), .cur(cur), .inc(inc), .dec(dec),
    .at_top(at_top), .at_bot(at_bot), .nxt(nxt), .nxt_dir_up(nxt_dir_up)
  );

  mmode_cnt_state #(.WIDTH(WIDTH)) u_state (
    .clk(clk), .rst(rst), .en(en), .nxt(nxt), .nxt_dir_up(nxt_dir_up),
    .cur(cur), .dir_up(dir_up)
  );

  assign count = cur;
endmodule

// File: rtl/mmode_counter_chk.sv
module mmode_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] TOP = '1;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  p_reset_zero_r1: assert property (@(posedge clk) rst |=> count == '0);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(count));

  p_wrap_step_r3: assert property (@(posedge clk) disable iff (rst)
    (en && mode == 2'b00) |=> count == $past(count) + ONE);

  p_sat_top_r4: assert property (@(posedge clk) disable iff (rst)
    (en && mode == 2'b01 && count == TOP) |=> count == TOP);

  p_sat_below_r4: assert property (@(posedge clk) disable iff (rst)
    (en && mode == 2'b01 && count != TOP) |=> count == $past(count) + ONE);

  p_bounce_unit_r5: assert property (@(posedge clk) disable iff (rst)
    (en && mode == 2'b10) |=>
      (count == $past(count) + ONE) || (count == $past(count) - ONE));

  p_bounce_peak_r5: assert property (@(posedge clk) disable iff (rst)
    (en && mode == 2'b10 && count == TOP) |=> count == TOP - ONE);

  p_bounce_floor_r5: assert property (@(posedge clk) disable iff (rst)
    (en && mode == 2'b10 && count == '0) |=> count == ONE);

  p_mode3_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (en && mode == 2'b11) |=> count == $past(count) + ONE);
endmodule

bind mmode_counter mmode_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .en(en), .mode(mode), .count(count)
);

// File: tb/sim_mmode_counter.sv
`timescale 1ns/1ps
module sim_mmode_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [3:0] count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mmode_counter u0 (.clk(clk), .rst(rst), .en(en), .mode(mode), .count(count));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input logic [3:0] exp, input string req);
    checks++;
    if (count !== exp) begin
      errors++;
      $display("FAIL %s: count=%0d expected=%0d", req, count, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; step(1); rst = 1'b0;
  endtask

  task automatic t_reset_r1();
    en = 1'b1; mode = 2'b10;
    do_reset();
    check(4'd0, "R1 reset state");
    step(1);
    check(4'd1, "R1 direction up after reset");
  endtask

  task automatic t_wrap_r3();
    do_reset(); mode = 2'b00; en = 1'b1;
    for (int i = 1; i <= 20; i++) begin
      step(1);
      check(4'(i % 16), "R3 wrap sequence");
    end
  endtask

  task automatic t_sat_r4();
    do_reset(); mode = 2'b01; en = 1'b1;
    for (int i = 1; i <= 19; i++) begin
      step(1);
      check((i > 15) ? 4'd15 : 4'(i), "R4 saturate sequence");
    end
  endtask

  task automatic t_bounce_r5();
    do_reset(); mode = 2'b10; en = 1'b1;
    for (int i = 1; i <= 34; i++) begin
      int e;
      if (i <= 15) e = i;
      else if (i <= 30) e = 30 - i;
      else e = i - 30;
      step(1);
      check(4'(e), "R5 bounce sequence");
    end
  endtask

  task automatic t_mode3_r6();
    do_reset(); mode = 2'b11; en = 1'b1;
    for (int i = 1; i <= 17; i++) begin
      step(1);
      check(4'(i % 16), "R6 mode 11 wraps");
    end
  endtask

  task automatic t_hold_r2();
    do_reset(); mode = 2'b10; en = 1'b1;
    step(16);
    check(4'd14, "R2 setup turned at top");
    en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step(1);
      check(4'd14, "R2 count held");
    end
    en = 1'b1; step(1);
    check(4'd13, "R2 direction held");
    en = 1'b0; mode = 2'b00; step(2);
    check(4'd13, "R2 hold ignores mode");
  endtask

  task automatic t_switch_r7();
    do_reset(); mode = 2'b10; en = 1'b1;
    step(20);
    check(4'd10, "R7 setup descending");
    mode = 2'b01; step(1);
    check(4'd11, "R7 keeps value on switch");
    mode = 2'b10; step(1);
    check(4'd12, "R7 direction forced up");
    mode = 2'b00; step(3);
    check(4'd15, "R7 wrap from current");
    mode = 2'b10; step(1);
    check(4'd14, "R7 bounce turns at top");
  endtask

  task automatic t_reset_prio_r1();
    do_reset(); mode = 2'b00; en = 1'b1;
    step(5);
    en = 1'b0; rst = 1'b1; step(1);
    check(4'd0, "R1 reset with enable low");
    rst = 1'b0; step(1);
    check(4'd0, "R1 held after reset");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: count=%0d expected=done", count);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset_r1();
    t_wrap_r3();
    t_sat_r4();
    t_bounce_r5();
    t_mode3_r6();
    t_hold_r2();
    t_switch_r7();
    t_reset_prio_r1();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule